// File: doc/BRIEF.md
# Stream-to-Raster Video Bridge with Frame Lock

This block turns a pixel stream into raster video. The stream carries a start-of-frame marker on the first pixel of a frame and an end-of-line marker on the last pixel of each line. The raster timing comes from an external generator as hsync, vsync, hblank, vblank and an active-video flag. Pixels enter a small buffer. The bridge pulls one pixel from the buffer for every active timing sample and emits it with one cycle of latency. Syncs and blanks are re-registered so that they stay aligned with the data.

Alignment is chosen when the block is built. In master mode the timing generator runs on its own, and the bridge slows the stream through its ready output. In slave mode the source may not tolerate arbitrary throttling. The bridge then drives the generator's clock enable low, which pauses the raster until buffered pixels can meet it. A locked flag shows when a stream frame lines up with a timing frame. The bridge drops the flag and hunts again when it loses alignment. The stream, the timing and the video output all run on one pixel clock, which must be the true pixel rate of the format (for example, about 148.5 MHz for 1080p60).

Top module: `vid_out_bridge`

## Requirements
- R1: With SLAVE_MODE=0, timCe is 1 in every cycle. The only throttling in this mode comes from sTready.
- R2: With SLAVE_MODE=1, timCe is 0 in two cases. The first is while unlocked, when the timing sample is the first active pixel of a frame and the buffer head is not a start-of-frame beat. The second is while locked, when the timing sample is active and the buffer is empty. In all other cycles timCe is 1.
- R3: The pixel buffer holds FIFO_DEPTH beats. sTready is 1 exactly when the buffer is not full, and the buffer never overflows.
- R4: While unlocked, a head beat with sTuser=0 is discarded, one beat per cycle. This happens whatever timCe is.
- R5: Lock is taken on the first active timing sample after a sample with vblank=1, provided the head beat has sTuser=1. That beat is the first output pixel. locked rises on the same clock edge on which vidDe first goes high.
- R6: A timing sample is taken in each cycle with timCe=1. vidHsync, vidVsync, vidHblank and vidVblank are that sample registered one cycle later. They hold their value after a cycle with timCe=0.
- R7: vidDe is 1 only for a locked, active timing sample taken with timCe=1. Whenever vidDe is 0, vidData is 0.
- R8: While locked, each active timing sample emits the next buffered pixel in stream order. A pixel at raster column x and row y therefore appears one cycle after the sample for (x,y).
- R9: If an active timing sample finds the buffer empty while locked (this can happen only in master mode), locked falls at that edge and the bridge returns to hunting.
- R10: While locked, the previous output pixel must carry sTlast=1 exactly when the current timing sample is not active, given that the previous sample was active. On a mismatch locked falls and the bridge hunts again.
- R11: In slave mode, once locked, the bridge stays locked through any gap in sTvalid, as long as the stream itself is well formed.
- R12: During reset, locked, vidDe, vidData and every video sync and blank output are 0, and sTready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock shared by stream, timing and video |
| rst_n | input | 1 | Active-low synchronous reset |
| sTdata | input | DATA_W | Stream pixel |
| sTvalid | input | 1 | Stream beat valid |
| sTuser | input | 1 | Start of frame on this beat |
| sTlast | input | 1 | Last pixel of a line on this beat |
| sTready | output | 1 | Buffer can accept a beat |
| timHsync | input | 1 | Timing horizontal sync |
| timVsync | input | 1 | Timing vertical sync |
| timHblank | input | 1 | Timing horizontal blank |
| timVblank | input | 1 | Timing vertical blank |
| timActive | input | 1 | Timing active video |
| timCe | output | 1 | Clock enable for the timing generator |
| vidData | output | DATA_W | Output pixel, zero in blanking |
| vidHsync | output | 1 | Delayed horizontal sync |
| vidVsync | output | 1 | Delayed vertical sync |
| vidHblank | output | 1 | Delayed horizontal blank |
| vidVblank | output | 1 | Delayed vertical blank |
| vidDe | output | 1 | Output data enable |
| locked | output | 1 | Stream and timing frames aligned |

## Verification
The hardest states to reach are a loss of lock in the middle of a frame and the recovery that follows. Reaching them needs a buffer that has fully drained during active video, or one wrong end-of-line marker deep inside a frame. The stimulus reaches the first by silencing the master-mode source for several lines, and the second by arming a one-shot fault that moves the marker of one line one pixel early. Both runs then check that the bridge discards the stale beats and locks again at a later frame start. A slave-mode source kept slower than the raster forces the clock enable to stall in the middle of lines, so the no-underflow path is exercised under random gaps.

// File: rtl/vob_pkg.sv
package vob_pkg;
  typedef struct packed {
    logic beat;  // timing sample consumed this cycle
    logic emit;  // head pixel goes to the video output
    logic pop;   // head leaves the buffer (emit or discard)
  } vobStrobe_t;

  typedef enum logic {HUNT = 1'b0, LOCK = 1'b1} vobState_t;
endpackage

// File: rtl/vob_fifo.sv
module vob_fifo #(
  parameter int WIDTH = 26,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             notEmpty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  assign notEmpty = (count != '0);
  assign full     = (count == CW'(DEPTH));
  assign rdData   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (rdEn) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn |-> count != '0);
endmodule

// File: rtl/vob_datapath.sv
module vob_datapath import vob_pkg::*; #(
  parameter int DATA_W     = 24,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sTdata,
  input  logic              sTvalid,
  input  logic              sTuser,
  input  logic              sTlast,
  output logic              sTready,
  input  logic              timHsync,
  input  logic              timVsync,
  input  logic              timHblank,
  input  logic              timVblank,
  input  vobStrobe_t        strobe,
  output logic              headValid,
  output logic              headSof,
  output logic              headLast,
  output logic [DATA_W-1:0] vidData,
  output logic              vidHsync,
  output logic              vidVsync,
  output logic              vidHblank,
  output logic              vidVblank,
  output logic              vidDe
);
  localparam int EW = DATA_W + 2;

  logic [EW-1:0] wrEntry, headEntry;
  logic          bufFull, push;

  assign wrEntry = {sTuser, sTlast, sTdata};
  assign push    = sTvalid && !bufFull;
  assign sTready = !bufFull;

  vob_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (push),
    .wrData  (wrEntry),
    .rdEn    (strobe.pop),
    .rdData  (headEntry),
    .notEmpty(headValid),
    .full    (bufFull)
  );

  assign headSof  = headEntry[EW-1];
  assign headLast = headEntry[EW-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vidData   <= '0;
      vidDe     <= 1'b0;
      vidHsync  <= 1'b0;
      vidVsync  <= 1'b0;
      vidHblank <= 1'b0;
      vidVblank <= 1'b0;
    end else if (strobe.beat) begin
      vidDe     <= strobe.emit;
      vidData   <= strobe.emit ? headEntry[DATA_W-1:0] : '0;
      vidHsync  <= timHsync;
      vidVsync  <= timVsync;
      vidHblank <= timHblank;
      vidVblank <= timVblank;
    end else begin
      vidDe   <= 1'b0;
      vidData <= '0;
    end
  end

  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(strobe.beat) |->
      (vidHsync == $past(timHsync)) && (vidVblank == $past(timVblank)));
  assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(strobe.beat) |-> $stable(vidVsync) && $stable(vidHblank));
endmodule

// File: rtl/vob_control.sv
module vob_control import vob_pkg::*; #(
  parameter bit SLAVE_MODE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       headValid,
  input  logic       headSof,
  input  logic       headLast,
  input  logic       timActive,
  input  logic       timVblank,
  output vobStrobe_t strobe,
  output logic       timCe,
  output logic       locked
);
  vobState_t stateQ, stateD;
  logic armedQ, prevActQ, lastTlastQ;
  logic frameStart, headIsSof, ceInt, errTlast, errUnder, emit, drop, isLock;

  assign isLock     = (stateQ == LOCK);
  assign frameStart = armedQ && timActive;
  assign headIsSof  = headValid && headSof;

  generate
    if (SLAVE_MODE) begin : g_slave
      assign ceInt = !((!isLock && frameStart && !headIsSof) ||
                       (isLock && timActive && !headValid));
    end else begin : g_master
      assign ceInt = 1'b1;
    end
  endgenerate

  assign errTlast = isLock && ceInt && prevActQ && (lastTlastQ == timActive);
  assign errUnder = isLock && ceInt && timActive && !headValid;
  assign emit = ceInt && timActive && headValid &&
                ((isLock && !errTlast && !errUnder) || (!isLock && frameStart && headSof));
  assign drop = !isLock && headValid && !headSof;

  always_comb begin
    strobe.beat = ceInt;
    strobe.emit = emit;
    strobe.pop  = emit || drop;
  end

  always_comb begin
    stateD = stateQ;
    if (errTlast || errUnder)  stateD = HUNT;
    else if (!isLock && emit)  stateD = LOCK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ     <= HUNT;
      armedQ     <= 1'b0;
      prevActQ   <= 1'b0;
      lastTlastQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ceInt) begin
        prevActQ <= timActive;
        if (timVblank)      armedQ <= 1'b1;
        else if (timActive) armedQ <= 1'b0;
      end
      if (emit) lastTlastQ <= headLast;
    end
  end

  assign timCe  = ceInt;
  assign locked = isLock;

  assert_lock_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(headSof) && $past(timActive));

  generate
    if (SLAVE_MODE) begin : g_slave_chk
      assert_slave_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        locked && timActive && timCe |-> headValid);
    end
  endgenerate
endmodule

// File: rtl/vid_out_bridge.sv
module vid_out_bridge import vob_pkg::*; #(
  parameter int DATA_W     = 24,
  parameter int FIFO_DEPTH = 16,
  parameter bit SLAVE_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sTdata,
  input  logic              sTvalid,
  input  logic              sTuser,
  input  logic              sTlast,
  output logic              sTready,
  input  logic              timHsync,
  input  logic              timVsync,
  input  logic              timHblank,
  input  logic              timVblank,
  input  logic              timActive,
  output logic              timCe,
  output logic [DATA_W-1:0] vidData,
  output logic              vidHsync,
  output logic              vidVsync,
  output logic              vidHblank,
  output logic              vidVblank,
  output logic              vidDe,
  output logic              locked
);
  vobStrobe_t strobe;
  logic headValid, headSof, headLast;

  vob_control #(.SLAVE_MODE(SLAVE_MODE)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .headValid(headValid),
    .headSof  (headSof),
    .headLast (headLast),
    .timActive(timActive),
    .timVblank(timVblank),
    .strobe   (strobe),
    .timCe    (timCe),
    .locked   (locked)
  );

  vob_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sTdata   (sTdata),
    .sTvalid  (sTvalid),
    .sTuser   (sTuser),
    .sTlast   (sTlast),
    .sTready  (sTready),
    .timHsync (timHsync),
    .timVsync (timVsync),
    .timHblank(timHblank),
    .timVblank(timVblank),
    .strobe   (strobe),
    .headValid(headValid),
    .headSof  (headSof),
    .headLast (headLast),
    .vidData  (vidData),
    .vidHsync (vidHsync),
    .vidVsync (vidVsync),
    .vidHblank(vidHblank),
    .vidVblank(vidVblank),
    .vidDe    (vidDe)
  );

  assert_de_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vidDe |-> $past(timActive) && $past(timCe) && locked);
endmodule

// File: tb/tb_vid_out_bridge.sv
`timescale 1ns/1ps

module tb_timgen (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  output int   hc,
  output int   vc,
  output logic hs,
  output logic vs,
  output logic hb,
  output logic vb,
  output logic act
);
  always @(posedge clk) begin
    if (!rst_n) begin
      hc <= 0;
      vc <= 0;
    end else if (ce) begin
      if (hc == 11) begin
        hc <= 0;
        vc <= (vc == 6) ? 0 : vc + 1;
      end else hc <= hc + 1;
    end
  end
  always_comb begin
    hb  = (hc >= 8);
    vb  = (vc >= 4);
    act = !hb && !vb;
    hs  = (hc == 9) || (hc == 10);
    vs  = (vc == 5);
  end
endmodule

module tb_src #(parameter int PCT = 90, parameter int START_Y = 0) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        corruptReq,
  input  logic        ready,
  output logic [23:0] data,
  output logic        valid,
  output logic        user,
  output logic        last
);
  int x, y, frm;
  bit pend;
  logic acc;
  always @(posedge clk) acc <= valid && ready;
  initial begin
    valid = 0; data = 0; user = 0; last = 0;
    x = 0; y = START_Y; frm = 0; pend = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        valid = 0; x = 0; y = START_Y; frm = 0; pend = 0;
      end else begin
        if (acc) begin
          if (pend && y == 1 && x == 6) pend = 0;
          x++;
          if (x == 8) begin
            x = 0; y++;
            if (y == 4) begin y = 0; frm++; end
          end
        end
        if (corruptReq) pend = 1;
        if (!valid || acc) valid = en && ($urandom_range(99) < PCT);
      end
      data = {frm[7:0], y[7:0], x[7:0]};
      user = (x == 0) && (y == 0);
      last = (x == 7) || (pend && y == 1 && x == 6);
    end
  end
endmodule

module tb_mon #(parameter bit MASTER = 1'b1, parameter string TAG = "M") (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce,
  input  int          hc,
  input  int          vc,
  input  logic        hs,
  input  logic        vb,
  input  logic        act,
  input  logic [23:0] vidData,
  input  logic        vidDe,
  input  logic        vidHs,
  input  logic        vidVb,
  input  logic        locked,
  output int          nChecks,
  output int          nFails,
  output int          nRise,
  output int          nFall,
  output int          nStall
);
  logic pRst, pBeat, pHs, pVb, pAct;
  int pHc, pVc;
  logic pLk;

  always @(posedge clk) begin
    pRst <= rst_n; pBeat <= ce; pHs <= hs; pVb <= vb; pAct <= act;
    pHc <= hc; pVc <= vc;
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, TAG, $time, act_v, exp_v);
    end
  endtask

  initial begin
    nChecks = 0; nFails = 0; nRise = 0; nFall = 0; nStall = 0; pLk = 0;
    forever begin
      @(negedge clk);
      if (rst_n && pRst) begin
        if (MASTER) chk(ce == 1'b1, "R1 ce high", int'(ce), 1);
        if (locked && !ce) nStall++;
        if (pBeat) begin
          chk(vidHs == pHs, "R6 hsync delay", int'(vidHs), int'(pHs));
          chk(vidVb == pVb, "R6 vblank delay", int'(vidVb), int'(pVb));
          if (locked) chk(vidDe == pAct, "R8 de per active sample", int'(vidDe), int'(pAct));
        end else begin
          chk(vidDe == 1'b0, "R7 de low without beat", int'(vidDe), 0);
        end
        if (!vidDe) chk(vidData == 24'h0, "R7 blank data zero", int'(vidData), 0);
        else chk(vidData[15:0] == {pVc[7:0], pHc[7:0]}, "R8 pixel position",
                 int'(vidData[15:0]), int'({pVc[7:0], pHc[7:0]}));
        if (locked && !pLk) begin
          nRise++;
          chk(vidDe && vidData[15:0] == 16'h0, "R5 first pixel is frame start",
              int'(vidData[15:0]), 0);
        end
        if (!locked && pLk) nFall++;
        pLk = locked;
      end else pLk = 0;
    end
  end
endmodule

module tb_vid_out_bridge;
  logic clk = 0;
  logic rst_n = 0;
  always #4 clk = ~clk;

  logic enM = 1, enS = 0, corrM = 0, noCorr = 0;
  bit done = 0, sawBp = 0;
  int nChecks = 0, nFails = 0;

  // master instance
  logic [23:0] dM, vdM;
  logic vM, uM, lM, rM, ceM, vhsM, vvsM, vhbM, vvbM, deM, lkM;
  int hcM, vcM;
  logic hsM, vsM, hbM, vbM, actM;
  int mChk, mFail, riseM, fallM, stallM;

  tb_timgen genM (.clk(clk), .rst_n(rst_n), .ce(ceM), .hc(hcM), .vc(vcM),
                  .hs(hsM), .vs(vsM), .hb(hbM), .vb(vbM), .act(actM));
  tb_src #(.PCT(90), .START_Y(2)) srcM (.clk(clk), .rst_n(rst_n), .en(enM),
                  .corruptReq(corrM), .ready(rM), .data(dM), .valid(vM), .user(uM), .last(lM));
  vid_out_bridge #(.DATA_W(24), .FIFO_DEPTH(16), .SLAVE_MODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .sTdata(dM), .sTvalid(vM), .sTuser(uM), .sTlast(lM),
    .sTready(rM), .timHsync(hsM), .timVsync(vsM), .timHblank(hbM), .timVblank(vbM),
    .timActive(actM), .timCe(ceM), .vidData(vdM), .vidHsync(vhsM), .vidVsync(vvsM),
    .vidHblank(vhbM), .vidVblank(vvbM), .vidDe(deM), .locked(lkM));
  tb_mon #(.MASTER(1'b1), .TAG("master")) monM (.clk(clk), .rst_n(rst_n), .ce(ceM),
    .hc(hcM), .vc(vcM), .hs(hsM), .vb(vbM), .act(actM), .vidData(vdM), .vidDe(deM),
    .vidHs(vhsM), .vidVb(vvbM), .locked(lkM), .nChecks(mChk), .nFails(mFail),
    .nRise(riseM), .nFall(fallM), .nStall(stallM));

  // slave instance
  logic [23:0] dS, vdS;
  logic vS, uS, lS, rS, ceS, vhsS, vvsS, vhbS, vvbS, deS, lkS;
  int hcS, vcS;
  logic hsS, vsS, hbS, vbS, actS;
  int sChk, sFail, riseS, fallS, stallS;

  tb_timgen genS (.clk(clk), .rst_n(rst_n), .ce(ceS), .hc(hcS), .vc(vcS),
                  .hs(hsS), .vs(vsS), .hb(hbS), .vb(vbS), .act(actS));
  tb_src #(.PCT(30), .START_Y(0)) srcS (.clk(clk), .rst_n(rst_n), .en(enS),
                  .corruptReq(noCorr), .ready(rS), .data(dS), .valid(vS), .user(uS), .last(lS));
  vid_out_bridge #(.DATA_W(24), .FIFO_DEPTH(8), .SLAVE_MODE(1'b1)) dutS (
    .clk(clk), .rst_n(rst_n), .sTdata(dS), .sTvalid(vS), .sTuser(uS), .sTlast(lS),
    .sTready(rS), .timHsync(hsS), .timVsync(vsS), .timHblank(hbS), .timVblank(vbS),
    .timActive(actS), .timCe(ceS), .vidData(vdS), .vidHsync(vhsS), .vidVsync(vvsS),
    .vidHblank(vhbS), .vidVblank(vvbS), .vidDe(deS), .locked(lkS));
  tb_mon #(.MASTER(1'b0), .TAG("slave")) monS (.clk(clk), .rst_n(rst_n), .ce(ceS),
    .hc(hcS), .vc(vcS), .hs(hsS), .vb(vbS), .act(actS), .vidData(vdS), .vidDe(deS),
    .vidHs(vhsS), .vidVb(vvbS), .locked(lkS), .nChecks(sChk), .nFails(sFail),
    .nRise(riseS), .nFall(fallS), .nStall(stallS));

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act_v, exp_v);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks + mChk + sChk, nFails + mFail + sFail);
    $finish;
  endtask

  initial forever begin
    @(negedge clk);
    if (rst_n && !rM) sawBp = 1;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    // R12: reset state
    chk(lkM == 0 && lkS == 0, "R12 locked in reset", int'(lkM), 0);
    chk(deM == 0 && vdM == 0 && vhsM == 0 && vvbM == 0, "R12 video in reset", int'(vdM), 0);
    chk(rM == 1 && rS == 1, "R12 ready in reset", int'(rM), 1);
    rst_n = 1;
    repeat (300) @(negedge clk);
    // R2: slave waits at frame start with no stream
    chk(ceS == 0, "R2 slave ce held low at frame start", int'(ceS), 0);
    chk(hcS == 0 && vcS == 0, "R2 slave raster parked", hcS + 100 * vcS, 0);
    chk(lkS == 0, "R2 slave unlocked without stream", int'(lkS), 0);
    // R4/R5: master started mid-frame, discarded to frame start, locked once
    chk(lkM == 1, "R5 master locked", int'(lkM), 1);
    chk(riseM == 1, "R4 single lock after discard", riseM, 1);
    chk(sawBp, "R3 back-pressure seen", int'(sawBp), 1);
    enS = 1;
    repeat (1500) @(negedge clk);
    chk(lkS == 1, "R11 slave locked", int'(lkS), 1);
    chk(riseS == 1 && fallS == 0, "R11 slave never lost lock", fallS, 0);
    chk(stallS > 0, "R2 slave ce stalls while locked", stallS, 1);
    // R9: underflow in master
    enM = 0;
    repeat (400) @(negedge clk);
    chk(lkM == 0, "R9 unlock on underflow", int'(lkM), 0);
    chk(fallM == 1, "R9 one fall", fallM, 1);
    enM = 1;
    repeat (600) @(negedge clk);
    chk(lkM == 1 && riseM == 2, "R9 relock after underflow", riseM, 2);
    // R10: one early end-of-line marker
    corrM = 1;
    @(negedge clk);
    corrM = 0;
    repeat (300) @(negedge clk);
    chk(fallM == 2, "R10 unlock on tlast mismatch", fallM, 2);
    repeat (600) @(negedge clk);
    chk(lkM == 1 && riseM == 3, "R10 relock after mismatch", riseM, 3);
    chk(fallS == 0, "R11 slave lock kept", fallS, 0);
    done = 1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end
endmodule